// File: doc/BRIEF.md
# ADC Result Formatter and Threshold Watchdog

This block sits after an analog-to-digital converter. Each finished 10-bit conversion arrives with a 5-bit channel number and a flag that marks it as an injected conversion. The block keeps the latest result for every channel. On a register read it returns the result formatted into a 16-bit field. The injection flag and a valid bit are packed into the upper half-word, so software fetches the value and its origin in one 32-bit access. Reading a result word consumes it and clears its valid bit.

Four threshold comparators watch the incoming stream. Each comparator has its own lower and upper limit, a channel select and a mode. A comparator can flag a result above its upper limit, below its lower limit, or outside the window formed by the two. A hit sets a sticky alarm flag, which software clears by writing 1 to it. A maskable interrupt output reports any alarm that is enabled.

The register port is a single-cycle read/write port with combinational read data. Address map:
- 0x00: bit 0 selects left alignment.
- 0x01: bits 3:0 are the alarm enables.
- 0x02: bits 3:0 are the alarm flags.
- 0x08+k: comparator k.
- 0x20+c: the result word of channel c.

Top module: `adc_result_fmt_wdog`

## Requirements
- R1: With alignment bit 0 of address 0x00 clear, a result word carries the 10-bit result in bits 9:0, and bits 15:10 read zero.
- R2: With that bit set, the result sits in bits 15:6, and bits 5:0 read zero. The setting applies to stored results at read time.
- R3: A result word at 0x20+c returns, in one read, the formatted result in bits 15:0, the injection flag in bit 16 and the valid bit in bit 31. All other bits read zero.
- R4: A read of a result word with the read strobe high clears that channel's valid bit after the clock edge. A read of another channel leaves it set.
- R5: An incoming result sets the channel's valid bit and overwrites both the stored value and the injection flag. A result that arrives in the same cycle as a clearing read wins.
- R6: Comparator word layout: lower limit in bits 9:0, channel in bits 14:10, upper limit in bits 25:16, mode in bits 27:26. In mode 1, a result strictly greater than the upper limit is a hit. A result equal to the upper limit is not.
- R7: In mode 2, a result strictly less than the lower limit is a hit. A result equal to the lower limit is not.
- R8: In mode 3, a result above the upper limit or below the lower limit is a hit. A result inside the window, limits included, is not.
- R9: A comparator ignores results from channels other than its selected one. In mode 0 it never hits.
- R10: A hit on comparator k sets flag bit k one clock later. Flags stay set. Writing 1 to a flag bit at 0x02 clears that bit, and writing 0 leaves it unchanged.
- R11: The interrupt output is high exactly when some flag bit and its enable bit at 0x01 are both set.
- R12: A hit and a clearing write to the same flag in the same cycle leave the flag set.
- R13: After reset, all configuration, flags, valid bits and the interrupt output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid_i | input | 1 | A completed conversion is presented |
| res_data_i | input | 10 | Conversion result |
| res_ch_i | input | 5 | Channel of the result |
| res_inj_i | input | 1 | Result came from an injected conversion |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (consumes result words) |
| addr_i | input | 6 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | OR of enabled alarm flags |

## Verification
The hardest situations to reach from the ports are cycle collisions. One is a comparator hit landing in the same clock as a write-1-to-clear of that flag. The other is a fresh conversion for a channel arriving in the same clock as a consuming read of that channel. The directed tasks drive the result strobe and the register strobe on the same falling edge to force both collisions. Each task then reads back the flag or the valid bit. The threshold tasks also place values exactly on each limit and one count beyond it, which separates strict comparisons from inclusive ones.

// File: rtl/adc_result_fmt_wdog.sv
module adc_result_fmt_wdog #(
  parameter int RES_W  = 10,
  parameter int CH_W   = 5,
  parameter int NCMP   = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid_i,
  input  logic [RES_W-1:0]  res_data_i,
  input  logic [CH_W-1:0]   res_ch_i,
  input  logic              res_inj_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int NCH  = 1 << CH_W;
  localparam int FILL = 16 - RES_W;
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(2);
  localparam int A_CMP = 8;

  logic                align_q;
  logic [NCMP-1:0]     alm_en_q, alarm_q, hit;
  logic [RES_W-1:0]    lo_q [NCMP];
  logic [RES_W-1:0]    hi_q [NCMP];
  logic [CH_W-1:0]     sel_q [NCMP];
  logic [1:0]          mode_q [NCMP];
  logic [RES_W-1:0]    res_q [NCH];
  logic [NCH-1:0]      inj_q, vld_q;

  wire res_area = addr_i[ADDR_W-1];
  wire [CH_W-1:0] rd_ch = addr_i[CH_W-1:0];
  wire flag_wr = wr_en_i && addr_i == A_FLAG;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      align_q  <= 1'b0;
      alm_en_q <= '0;
      alarm_q  <= '0;
    end else begin
      if (wr_en_i && addr_i == A_CFG) align_q  <= wdata_i[0];
      if (wr_en_i && addr_i == A_EN)  alm_en_q <= wdata_i[NCMP-1:0];
      alarm_q <= (alarm_q & ~(flag_wr ? wdata_i[NCMP-1:0] : '0)) | hit;
    end

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        lo_q[k] <= '0; hi_q[k] <= '0; sel_q[k] <= '0; mode_q[k] <= '0;
      end else if (wr_en_i && addr_i == ADDR_W'(A_CMP + k)) begin
        lo_q[k]   <= wdata_i[RES_W-1:0];
        sel_q[k]  <= wdata_i[10 +: CH_W];
        hi_q[k]   <= wdata_i[16 +: RES_W];
        mode_q[k] <= wdata_i[27:26];
      end

    assign hit[k] = res_valid_i && sel_q[k] == res_ch_i &&
                    ((mode_q[k][0] && res_data_i > hi_q[k]) ||
                     (mode_q[k][1] && res_data_i < lo_q[k]));

    assert_mode0_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_q[k]) |-> ($past(mode_q[k]) != 2'd0 && $past(res_valid_i)));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vld_q <= '0;
      inj_q <= '0;
      for (int c = 0; c < NCH; c++) res_q[c] <= '0;
    end else begin
      for (int c = 0; c < NCH; c++)
        if (res_valid_i && res_ch_i == CH_W'(c)) begin
          res_q[c] <= res_data_i;
          inj_q[c] <= res_inj_i;
          vld_q[c] <= 1'b1;
        end else if (rd_en_i && res_area && rd_ch == CH_W'(c)) begin
          vld_q[c] <= 1'b0;
        end
    end

  always_comb begin
    rdata_o = '0;
    if (res_area)
      rdata_o = {vld_q[rd_ch], 14'b0, inj_q[rd_ch],
                 align_q ? {res_q[rd_ch], FILL'(0)} : {FILL'(0), res_q[rd_ch]}};
    else if (addr_i == A_CFG)  rdata_o[0] = align_q;
    else if (addr_i == A_EN)   rdata_o[NCMP-1:0] = alm_en_q;
    else if (addr_i == A_FLAG) rdata_o[NCMP-1:0] = alarm_q;
    else
      for (int k = 0; k < NCMP; k++)
        if (addr_i == ADDR_W'(A_CMP + k)) begin
          rdata_o[RES_W-1:0]   = lo_q[k];
          rdata_o[10 +: CH_W]  = sel_q[k];
          rdata_o[16 +: RES_W] = hi_q[k];
          rdata_o[27:26]       = mode_q[k];
        end
  end

  assign irq_o = |(alarm_q & alm_en_q);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((alarm_q & $past(alarm_q)) == $past(alarm_q)));

  assert_valid_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_i |=> vld_q[$past(res_ch_i)]);

  assert_valid_consume_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && res_area && !(res_valid_i && res_ch_i == rd_ch)) |=> !vld_q[$past(rd_ch)]);

  assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_en_q == '0) |-> !irq_o);
endmodule

// File: tb/adc_result_fmt_wdog_tb.sv
module adc_result_fmt_wdog_tb;
  logic clk = 0, rst_n = 0;
  logic res_valid_i = 0, res_inj_i = 0, wr_en_i = 0, rd_en_i = 0;
  logic [9:0] res_data_i = 0;
  logic [4:0] res_ch_i = 0;
  logic [5:0] addr_i = 0;
  logic [31:0] wdata_i = 0, rdata_o;
  logic irq_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  adc_result_fmt_wdog u_dut (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; wr_en_i = 1;
    @(negedge clk); wr_en_i = 0;
  endtask

  task automatic rd(logic [5:0] a, logic clr, output logic [31:0] d);
    @(negedge clk); addr_i = a; rd_en_i = clr; #1 d = rdata_o;
    @(negedge clk); rd_en_i = 0;
  endtask

  task automatic push(logic [4:0] ch, logic [9:0] v, logic inj);
    @(negedge clk); res_ch_i = ch; res_data_i = v; res_inj_i = inj; res_valid_i = 1;
    @(negedge clk); res_valid_i = 0;
  endtask

  function automatic logic [31:0] cmpw(logic [9:0] lo, logic [9:0] hi, logic [4:0] ch, logic [1:0] m);
    return {4'b0, m, hi, 1'b0, ch, lo};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(6'h00, 0, d); chk("R13 cfg", d, 0);
    rd(6'h02, 0, d); chk("R13 flags", d, 0);
    rd(6'h23, 0, d); chk("R13 result", d, 0);
    chk("R13 irq", irq_o, 0);
  endtask

  task automatic t_format();
    logic [31:0] d;
    push(5'd3, 10'h2A5, 1);
    rd(6'h23, 0, d); chk("R1 R3 right", d, 32'h8001_02A5);
    wr(6'h00, 1);
    rd(6'h23, 0, d); chk("R2 R3 left", d, 32'h8001_A940);
  endtask

  task automatic t_valid();
    logic [31:0] d;
    push(5'd5, 10'h011, 0);
    rd(6'h24, 1, d);
    rd(6'h25, 0, d); chk("R4 other channel kept", d[31], 1);
    rd(6'h23, 1, d); chk("R4 consume read", d[31], 1);
    rd(6'h23, 0, d); chk("R4 valid cleared", d, 32'h0001_A940);
    push(5'd3, 10'h3FF, 0);
    rd(6'h23, 0, d); chk("R5 overwrite", d, 32'h8000_FFC0);
    @(negedge clk); addr_i = 6'h25; rd_en_i = 1;
    res_ch_i = 5'd5; res_data_i = 10'h022; res_inj_i = 1; res_valid_i = 1;
    @(negedge clk); rd_en_i = 0; res_valid_i = 0;
    rd(6'h25, 0, d); chk("R5 result beats clear", d, 32'h8001_0880);
    wr(6'h00, 0);
  endtask

  task automatic t_compare();
    logic [31:0] d;
    wr(6'h08, cmpw(10'd0, 10'd500, 5'd7, 2'd1));
    wr(6'h09, cmpw(10'd100, 10'd1023, 5'd7, 2'd2));
    wr(6'h0A, cmpw(10'd200, 10'd300, 5'd9, 2'd3));
    wr(6'h0B, cmpw(10'd1000, 10'd0, 5'd11, 2'd0));
    rd(6'h0A, 0, d); chk("R6 cmp layout", d, 32'h0D2C_24C8);
    push(5'd7, 10'd500, 0); rd(6'h02, 0, d); chk("R6 equal upper", d, 0);
    push(5'd7, 10'd501, 0); rd(6'h02, 0, d); chk("R6 above upper", d, 32'h1);
    push(5'd7, 10'd100, 0); rd(6'h02, 0, d); chk("R7 equal lower", d, 32'h1);
    push(5'd7, 10'd99, 0);  rd(6'h02, 0, d); chk("R7 below lower", d, 32'h3);
    push(5'd9, 10'd200, 0); push(5'd9, 10'd300, 0);
    rd(6'h02, 0, d); chk("R8 window edges", d, 32'h3);
    push(5'd9, 10'd301, 0); rd(6'h02, 0, d); chk("R8 high side", d, 32'h7);
    wr(6'h02, 32'h4);       rd(6'h02, 0, d); chk("R10 w1c", d, 32'h3);
    push(5'd9, 10'd199, 0); rd(6'h02, 0, d); chk("R8 low side", d, 32'h7);
    push(5'd10, 10'd1023, 0); push(5'd11, 10'd0, 0);
    rd(6'h02, 0, d); chk("R9 other ch and mode0", d, 32'h7);
  endtask

  task automatic t_alarm();
    logic [31:0] d;
    wr(6'h02, 32'h0); rd(6'h02, 0, d); chk("R10 write zero", d, 32'h7);
    chk("R11 masked", irq_o, 0);
    wr(6'h01, 32'h8); chk("R11 enable idle bit", irq_o, 0);
    wr(6'h01, 32'h2); chk("R11 enabled flag", irq_o, 1);
    wr(6'h02, 32'h2); chk("R11 cleared", irq_o, 0);
    @(negedge clk); addr_i = 6'h02; wdata_i = 32'h1; wr_en_i = 1;
    res_ch_i = 5'd7; res_data_i = 10'd600; res_valid_i = 1;
    @(negedge clk); wr_en_i = 0; res_valid_i = 0;
    rd(6'h02, 0, d); chk("R12 set wins", d[0], 1);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_format();
    t_valid();
    t_compare();
    t_alarm();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule